// File: doc/BRIEF.md
# MDIO Management Serial Slave

This block is the serial end of a management link for a single PHY. It turns a bit stream into accesses on a parallel register port. The host presents one event per management clock tick: either it drives a bit on the shared data pin (`host_wr_stb` with `host_wr_bit`), or it samples the pin (`host_rd_stb`). The slave keeps a seven-state decoder in step with those events.

A frame opens with a 0 followed by a 1. Twelve header bits follow: the opcode, the PHY address (ignored), and the register address. A read frame fetches the register in the same cycle that its last header bit arrives. It then drives a turnaround 0 and shifts out sixteen data bits. A write frame skips two turnaround bits, collects sixteen data bits, and issues one register write strobe.

Any protocol violation sends the decoder back to idle with no register access. A violation is an unknown opcode, a host sample outside the read phase, or a host-driven bit during the read phase. The register file sits outside this block and answers reads combinationally.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset the pin enable is low, no register strobe is active, and the decoder is idle.
- R2: In idle, driven 1 bits are ignored and a driven 0 starts a frame. The frame then waits, absorbing any further 0 bits, until a driven 1 arrives.
- R3: The twelve bits after the start are taken MSB first: a 2-bit opcode, a 5-bit PHY address that has no effect on the access, and a 5-bit register address. Read is opcode 10 and write is opcode 01.
- R4: For opcode 10, `reg_re` pulses for exactly the cycle of the twelfth header bit, with `reg_addr` equal to the received register address, and `reg_rdata` is captured in that cycle.
- R5: After a read header, the first host sample returns 0 with the pin enabled. The next sixteen samples return the captured word MSB first, and the pin enable drops after the sixteenth.
- R6: For opcode 01, the next two driven bits are ignored whatever their value. The sixteen bits after them are taken MSB first, and `reg_we` pulses once, in the cycle of the sixteenth bit, with the latched address and the assembled word. No write strobe appears earlier in the frame.
- R7: Opcodes 00 and 11 return the decoder to idle without any register strobe, and the next frame is decoded normally.
- R8: A host sample in any state other than the read turnaround or read data returns 0 and returns the decoder to idle. If it arrives during a write frame, that frame produces no register write.
- R9: A driven bit during the read turnaround or read data returns the decoder to idle, and the pin enable drops on the next cycle.
- R10: `mdio_oe` is high only while the decoder is in the read turnaround or read data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_stb | input | 1 | Host drives a bit this tick |
| host_wr_bit | input | 1 | Value of the driven bit |
| host_rd_stb | input | 1 | Host samples the pin this tick |
| mdio_out | output | 1 | Value the slave presents on the pin |
| mdio_oe | output | 1 | Slave drives the pin |
| reg_addr | output | 5 | Register address toward the register file |
| reg_wdata | output | 16 | Write data toward the register file |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_re | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 16 | Read data from the register file |

## Verification
A wrong state or a miscounted bit shows up at the ports within the same frame. A stray pin enable would appear one cycle after the faulty transition, and the bench compares the enable every clock. An off-by-one in the turnaround or data count shifts the read word by one bit or moves the write strobe, so the write-then-readback pairs expose it at the end of the frame. A missed abort shows up as a register write that should not have happened, or as a changed value on the next readback.

// File: rtl/mdio_slv_pkg.sv
`timescale 1ns/1ps
package mdio_slv_pkg;
  localparam int OP_W = 2;
  localparam logic [OP_W-1:0] OPC_READ  = 2'b10;
  localparam logic [OP_W-1:0] OPC_WRITE = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_HDR,
    ST_TA_RD,
    ST_TA_WR,
    ST_RD,
    ST_WR
  } mstate_e;
endpackage

// File: rtl/mdio_slv_shift.sv
`timescale 1ns/1ps
module mdio_slv_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_in,
  input  logic         shift_out,
  input  logic         in_bit,
  output logic [W-1:0] acc_q,
  output logic [W-1:0] acc_in
);
  logic [W-1:0] acc_d;
  logic         acc_en;

  assign acc_in = {acc_q[W-2:0], in_bit};
  assign acc_en = clr | load | shift_in | shift_out;

  always_comb begin
    acc_d = acc_q;
    if (load)           acc_d = load_val;
    else if (clr)       acc_d = '0;
    else if (shift_in)  acc_d = acc_in;
    else if (shift_out) acc_d = {acc_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  // R4: the fetched word is held for shifting out
  assert_load_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (acc_q == $past(load_val)));
endmodule

// File: rtl/mdio_slv_ctrl.sv
`timescale 1ns/1ps
module mdio_slv_ctrl
  import mdio_slv_pkg::*;
#(
  parameter int HDR_BITS = 12,
  parameter int DATA_W   = 16,
  parameter int TA_BITS  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stb,
  input  logic            wr_bit,
  input  logic            rd_stb,
  input  logic [OP_W-1:0] hdr_op,
  output mstate_e         state_q,
  output logic            acc_clr,
  output logic            acc_shift_in,
  output logic            acc_shift_out,
  output logic            hdr_done,
  output logic            rd_fire,
  output logic            wr_fire
);
  localparam int MAXC  = (DATA_W > HDR_BITS) ? DATA_W : HDR_BITS;
  localparam int CNT_W = $clog2(MAXC + 1);

  mstate_e          state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last = (cnt_q == CNT_W'(1));

  always_comb begin
    state_d       = state_q;
    cnt_d         = cnt_q;
    acc_clr       = 1'b0;
    acc_shift_in  = 1'b0;
    acc_shift_out = 1'b0;
    hdr_done      = 1'b0;
    rd_fire       = 1'b0;
    wr_fire       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (wr_stb && !rd_stb && !wr_bit) state_d = ST_START;
      end
      ST_START: begin
        if (rd_stb) begin
          state_d = ST_IDLE;
        end else if (wr_stb && wr_bit) begin
          state_d = ST_HDR;
          cnt_d   = CNT_W'(HDR_BITS);
          acc_clr = 1'b1;
        end
      end
      ST_HDR: begin
        if (rd_stb) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (wr_stb) begin
          acc_shift_in = 1'b1;
          cnt_d        = cnt_q - CNT_W'(1);
          if (last) begin
            hdr_done = 1'b1;
            if (hdr_op == OPC_READ) begin
              rd_fire = 1'b1;
              state_d = ST_TA_RD;
              cnt_d   = CNT_W'(1);
            end else if (hdr_op == OPC_WRITE) begin
              state_d = ST_TA_WR;
              cnt_d   = CNT_W'(TA_BITS);
            end else begin
              state_d = ST_IDLE;
              cnt_d   = '0;
            end
          end
        end
      end
      ST_TA_RD: begin
        if (wr_stb) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (rd_stb) begin
          state_d = ST_RD;
          cnt_d   = CNT_W'(DATA_W);
        end
      end
      ST_RD: begin
        if (wr_stb) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (rd_stb) begin
          acc_shift_out = 1'b1;
          cnt_d         = cnt_q - CNT_W'(1);
          if (last) state_d = ST_IDLE;
        end
      end
      ST_TA_WR: begin
        if (rd_stb) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (wr_stb) begin
          cnt_d = cnt_q - CNT_W'(1);
          if (last) begin
            state_d = ST_WR;
            cnt_d   = CNT_W'(DATA_W);
          end
        end
      end
      ST_WR: begin
        if (rd_stb) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (wr_stb) begin
          acc_shift_in = 1'b1;
          cnt_d        = cnt_q - CNT_W'(1);
          if (last) begin
            wr_fire = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R8: a sample outside the read phase ends the frame
  assert_rd_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && state_q != ST_TA_RD && state_q != ST_RD) |=> (state_q == ST_IDLE));

  // R9: a driven bit inside the read phase ends the frame
  assert_wr_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (state_q == ST_TA_RD || state_q == ST_RD)) |=> (state_q == ST_IDLE));

  // R6: a write strobe closes the frame
  assert_write_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (state_q == ST_IDLE));
endmodule

// File: rtl/mdio_mgmt_slave.sv
`timescale 1ns/1ps
module mdio_mgmt_slave
  import mdio_slv_pkg::*;
#(
  parameter int PHY_AW  = 5,
  parameter int REG_AW  = 5,
  parameter int DATA_W  = 16,
  parameter int TA_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_stb,
  input  logic              host_wr_bit,
  input  logic              host_rd_stb,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic [REG_AW-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int HDR_BITS = OP_W + PHY_AW + REG_AW;

  mstate_e           state;
  logic              acc_clr, acc_shift_in, acc_shift_out, hdr_done;
  logic              rd_fire, wr_fire;
  logic [DATA_W-1:0] acc_q, acc_in;
  logic [OP_W-1:0]   hdr_op;
  logic [REG_AW-1:0] addr_q, hdr_addr;

  assign hdr_op   = acc_in[HDR_BITS-1 -: OP_W];
  assign hdr_addr = acc_in[REG_AW-1:0];

  mdio_slv_ctrl #(
    .HDR_BITS (HDR_BITS),
    .DATA_W   (DATA_W),
    .TA_BITS  (TA_BITS)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_stb        (host_wr_stb),
    .wr_bit        (host_wr_bit),
    .rd_stb        (host_rd_stb),
    .hdr_op        (hdr_op),
    .state_q       (state),
    .acc_clr       (acc_clr),
    .acc_shift_in  (acc_shift_in),
    .acc_shift_out (acc_shift_out),
    .hdr_done      (hdr_done),
    .rd_fire       (rd_fire),
    .wr_fire       (wr_fire)
  );

  mdio_slv_shift #(.W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (acc_clr),
    .load      (rd_fire),
    .load_val  (reg_rdata),
    .shift_in  (acc_shift_in),
    .shift_out (acc_shift_out),
    .in_bit    (host_wr_bit),
    .acc_q     (acc_q),
    .acc_in    (acc_in)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        addr_q <= '0;
    else if (hdr_done) addr_q <= hdr_addr;
  end

  assign reg_addr  = rd_fire ? hdr_addr : addr_q;
  assign reg_wdata = acc_in;
  assign reg_we    = wr_fire;
  assign reg_re    = rd_fire;
  assign mdio_oe   = (state == ST_TA_RD) || (state == ST_RD);
  assign mdio_out  = (state == ST_RD) ? acc_q[DATA_W-1] : 1'b0;

  // R5: a read fetch is followed by the driven turnaround zero
  assert_ta_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> (mdio_oe && !mdio_out));

  // R10: the enable never rises outside a read frame
  assert_oe_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> $past(reg_re));

  // R4: read and write strobes never overlap
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({reg_re, reg_we}) <= 1);
endmodule

// File: tb/mdio_mgmt_slave_test.sv
`timescale 1ns/1ps
module mdio_mgmt_slave_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_stb = 1'b0, host_wr_bit = 1'b0, host_rd_stb = 1'b0;
  logic        mdio_out, mdio_oe, reg_we, reg_re;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;

  logic [15:0] rf [32];
  logic [15:0] ref_rf [32];
  int          n_chk = 0, n_fail = 0, we_cnt = 0, re_cnt = 0;
  logic        exp_oe = 1'b0;
  logic        obs_o, obs_re, obs_we;
  logic [4:0]  obs_addr;
  logic [15:0] obs_wd;

  always #2 clk = ~clk;

  mdio_mgmt_slave uut (
    .clk(clk), .rst_n(rst_n), .host_wr_stb(host_wr_stb), .host_wr_bit(host_wr_bit),
    .host_rd_stb(host_rd_stb), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata)
  );

  assign reg_rdata = rf[reg_addr];

  always @(posedge clk) begin
    if (rst_n) begin
      if (reg_we) begin rf[reg_addr] <= reg_wdata; we_cnt++; end
      if (reg_re) re_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic w, input logic v, input logic r);
    @(negedge clk);
    chk("R10 enable per clock", 32'(mdio_oe), 32'(exp_oe));
    host_wr_stb = w; host_wr_bit = v; host_rd_stb = r;
    #1;
    obs_o = mdio_out; obs_re = reg_re; obs_we = reg_we;
    obs_addr = reg_addr; obs_wd = reg_wdata;
  endtask

  task automatic start_seq();
    tick(1, 1, 0); tick(1, 1, 0); tick(1, 0, 0); tick(1, 1, 0);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
    for (int i = 1; i >= 0; i--) tick(1, op[i], 0);
    for (int i = 4; i >= 0; i--) tick(1, phy[i], 0);
    for (int i = 4; i >= 0; i--) begin
      tick(1, ra[i], 0);
      if (i > 0) chk("R3 no strobe mid-header", 32'({obs_re, obs_we}), 32'd0);
    end
  endtask

  task automatic wr_frame(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d,
                          input logic ta0, input logic ta1);
    start_seq();
    send_hdr(2'b01, phy, ra);
    chk("R6 no read on write header", 32'({obs_re, obs_we}), 32'd0);
    tick(1, ta0, 0); tick(1, ta1, 0);
    for (int i = 15; i >= 0; i--) begin
      tick(1, d[i], 0);
      if (i > 0) chk("R6 no early write", 32'(obs_we), 32'd0);
    end
    chk("R6 write strobe", 32'(obs_we), 32'd1);
    chk("R6 write address", 32'(obs_addr), 32'(ra));
    chk("R6 write data", 32'(obs_wd), 32'(d));
    ref_rf[ra] = d;
    tick(0, 0, 0);
  endtask

  task automatic rd_frame(input logic [4:0] phy, input logic [4:0] ra);
    logic [15:0] got;
    start_seq();
    send_hdr(2'b10, phy, ra);
    chk("R4 read strobe", 32'({obs_re, obs_we}), 32'b10);
    chk("R4 read address", 32'(obs_addr), 32'(ra));
    exp_oe = 1'b1;
    tick(0, 0, 1);
    chk("R5 turnaround zero", 32'(obs_o), 32'd0);
    for (int i = 15; i >= 0; i--) begin
      tick(0, 0, 1);
      got[i] = obs_o;
    end
    exp_oe = 1'b0;
    chk("R5 readback word", 32'(got), 32'(ref_rf[ra]));
    tick(0, 0, 0);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int we0;
    for (int i = 0; i < 32; i++) begin
      rf[i]     = 16'(i * 16'h0505) ^ 16'hA0C3;
      ref_rf[i] = 16'(i * 16'h0505) ^ 16'hA0C3;
    end
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    tick(0, 0, 0);
    chk("R1 reset strobes", 32'({obs_re, obs_we}), 32'd0);
    chk("R1 reset enable", 32'(mdio_oe), 32'd0);

    // R2: long run of ones in idle, then a sample: nothing driven
    for (int i = 0; i < 20; i++) tick(1, 1, 0);
    tick(0, 0, 1);
    chk("R2 idle ignores ones", 32'(obs_o), 32'd0);

    // write / readback pairs, varied PHY address and turnaround values (R3, R6)
    wr_frame(5'd0, 5'd4, 16'h1234, 1'b1, 1'b0);
    rd_frame(5'd31, 5'd4);
    wr_frame(5'd17, 5'd31, 16'h8001, 1'b0, 1'b1);
    rd_frame(5'd2, 5'd31);
    wr_frame(5'd9, 5'd0, 16'hFFFF, 1'b1, 1'b1);
    rd_frame(5'd9, 5'd0);
    wr_frame(5'd3, 5'd16, 16'h0000, 1'b0, 1'b0);
    rd_frame(5'd3, 5'd16);
    rd_frame(5'd6, 5'd21);  // untouched register (R4)

    // R2: extra zeros while waiting for the start one
    tick(1, 0, 0); tick(1, 0, 0); tick(1, 0, 0); tick(1, 1, 0);
    send_hdr(2'b10, 5'd1, 5'd4);
    chk("R2 frame after extra zeros", 32'(obs_re), 32'd1);
    chk("R2 address after extra zeros", 32'(obs_addr), 32'd4);
    exp_oe = 1'b1;
    for (int i = 0; i < 17; i++) tick(0, 0, 1);
    exp_oe = 1'b0;
    tick(0, 0, 0);

    // R7: illegal opcodes
    we0 = we_cnt;
    start_seq(); send_hdr(2'b00, 5'd0, 5'd4);
    chk("R7 opcode 00 no access", 32'({obs_re, obs_we}), 32'd0);
    tick(0, 0, 0);
    start_seq(); send_hdr(2'b11, 5'd0, 5'd4);
    chk("R7 opcode 11 no access", 32'({obs_re, obs_we}), 32'd0);
    tick(0, 0, 0);
    chk("R7 no write count", 32'(we_cnt), 32'(we0));
    rd_frame(5'd0, 5'd4);

    // R8: sample during write data aborts the write
    we0 = we_cnt;
    start_seq(); send_hdr(2'b01, 5'd0, 5'd7);
    tick(1, 0, 0); tick(1, 0, 0);
    for (int i = 0; i < 5; i++) tick(1, 1, 0);
    tick(0, 0, 1);
    chk("R8 sample returns zero", 32'(obs_o), 32'd0);
    for (int i = 0; i < 14; i++) tick(1, 1, 0);
    chk("R8 aborted write", 32'(we_cnt), 32'(we0));
    rd_frame(5'd0, 5'd7);

    // R9: driven bit during read data aborts the read
    start_seq(); send_hdr(2'b10, 5'd0, 5'd4);
    exp_oe = 1'b1;
    for (int i = 0; i < 5; i++) tick(0, 0, 1);
    tick(1, 1, 0);
    exp_oe = 1'b0;
    tick(0, 0, 1);
    chk("R9 released after abort", 32'({obs_o, mdio_oe}), 32'd0);
    tick(0, 0, 0);
    rd_frame(5'd0, 5'd4);

    // R9: driven bit during read turnaround
    start_seq(); send_hdr(2'b10, 5'd0, 5'd31);
    exp_oe = 1'b1;
    tick(1, 1, 0);
    exp_oe = 1'b0;
    tick(0, 0, 0);
    chk("R9 turnaround abort", 32'(mdio_oe), 32'd0);
    rd_frame(5'd0, 5'd31);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule